// File: doc/BRIEF.md
# Resonant Synchronous Rectifier Gate Timer

This block times the gate of one synchronous rectifier switch on the secondary side of a resonant converter. Its input is a digitized low-detect flag. The flag is high while the switch's drain voltage sits below the conduction threshold. The block turns the gate on once that flag has held for a fixed delay. It measures how long each conduction interval lasts. In the following interval it turns the gate off early by the programmed dead time. All timing runs from a 100 MHz clock, counted in 10 ns units, and every duration counter saturates at 2047.

A pure prediction fails when the switching frequency rises quickly, so the prediction is cut short in three ways:

- A late turn-off seen in the previous interval shortens the next pulse.
- A conduction blip that looks like ringing near zero shortens the next pulse.
- A feedback shrink request, which is a level input, shortens the pulse while it is active.

Safeguards act on top of that prediction:

- a hard maximum on-time;
- a blanking window after turn-on;
- an inhibit time after turn-off, whose length depends on the frequency-range select;
- a 140 % limit on growth from one pulse to the next.

An enable input forces the gate low.

Top module: `sr_gate_timer`

## Requirements
- R1: The gate rises in the cycle after the 35th consecutive clock sample in which `low_det` is 1, which is 350 ns after the flag asserts.
- R2: A pulse lasts exactly P cycles, where P = M − `dead_cyc` − 35. M is the length in cycles of the most recent finished conduction interval that lasted at least 35 samples. The rules in R4 to R7, R10 and R11 modify or cancel P.
- R3: After reset, and until a conduction interval of at least 35 samples has ended, no pulse is issued. Intervals shorter than 35 samples never update M.
- R4: A pulse can end because `low_det` went to 0 rather than because its timer expired. A pulse can also end on its timer and be followed by `low_det` dropping within the next 13 cycles. In either case the next turn-on has P reduced by 125 cycles, and only that one turn-on.
- R5: A conduction interval shorter than 35 samples may be followed by at least 16 consecutive samples of `low_det` = 0. If so, the next turn-on has P reduced by 120 cycles, and only that one turn-on.
- R6: If `fb_shrink` is 1 at the turn-on sample, P is reduced by 140 cycles.
- R7: No pulse lasts more than 1050 cycles.
- R8: During the first 30 cycles of a pulse, `low_det` returning to 0 does not end it. After that, the pulse ends at the first sample with `low_det` = 0.
- R9: After the gate falls, no turn-on occurs for 210 cycles when `hf_sel` = 0, or for 145 cycles when `hf_sel` = 1. The value of `hf_sel` at the falling edge selects the length. A turn-on sample that falls inside this window is skipped.
- R10: If an earlier pulse exists, P is limited to floor(7 × L / 5), where L is the length of the most recent pulse.
- R11: If P after the shrinks is zero or negative, that turn-on is skipped.
- R12: When `en` is 0, `gate` is 0 at once and any pulse in progress ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Gate enable |
| low_det | input | 1 | 1 while the drain voltage is below threshold |
| hf_sel | input | 1 | 1 selects the short (high-frequency) inhibit |
| fb_shrink | input | 1 | Feedback-driven shrink request |
| dead_cyc | input | 11 | Dead time in 10 ns cycles |
| gate | output | 1 | Rectifier gate command |

## Verification
Embedded assertions check these properties on every cycle:

- the gate is released after `en` drops;
- the pulse length never exceeds the cap;
- a rise occurs only with the inhibit window expired and a measurement held;
- a rise lines up with the 35th conduction sample;
- a pulse never exceeds 140 % of its predecessor;
- a pulse is never cut inside its blanking window.

The exact pulse arithmetic can only be shown by the bench's scenarios, where measurement minus dead time is checked against observed widths. The same applies to:

- each shrink amount, and the fact that a shrink is consumed once;
- the qualification of ringing against short gaps;
- the skip of pulses with zero or negative length;
- the frequency-dependent inhibit.

// File: rtl/sr_gate_timer.sv
module sr_gate_timer #(
  parameter int CW       = 11,
  parameter int ON_DLY   = 35,
  parameter int BLANK    = 30,
  parameter int T_MAX    = 1050,
  parameter int DW_WIN   = 13,
  parameter int SH_DT    = 125,
  parameter int SH_RNG   = 120,
  parameter int SH_FB    = 140,
  parameter int RNG_WIN  = 35,
  parameter int RNG_HOLD = 15,
  parameter int INH_LF   = 210,
  parameter int INH_HF   = 145
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          low_det,
  input  logic          hf_sel,
  input  logic          fb_shrink,
  input  logic [CW-1:0] dead_cyc,
  output logic          gate
);

  localparam int SW = CW + 4;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] low_cnt, hi_cnt, meas, prev_on, on_cnt, on_tgt, inh_cnt, dw_cnt;
  logic          meas_vld, g_q, dt_sh, rg_sh, rg_arm;
  logic signed [SW-1:0] raw;
  logic [SW-1:0] grow, lenv;

  wire fall = !low_det && (low_cnt != '0);
  wire ton  = low_det && (low_cnt == CW'(ON_DLY - 1));
  wire ring_hit = rg_arm && !low_det && (hi_cnt >= CW'(RNG_HOLD));

  always_comb begin
    raw  = SW'(meas) - SW'(dead_cyc) - SW'(ON_DLY)
         - (dt_sh ? SW'(SH_DT) : SW'(0))
         - (rg_sh ? SW'(SH_RNG) : SW'(0))
         - (fb_shrink ? SW'(SH_FB) : SW'(0));
    grow = (SW'(prev_on) * SW'(7)) / SW'(5);
    lenv = $unsigned(raw);
    if (prev_on != '0 && lenv > grow) lenv = grow;
    if (lenv > SW'(T_MAX)) lenv = SW'(T_MAX);
  end

  wire len_ok   = !raw[SW-1] && (raw != '0);
  wire off      = g_q && (!en || on_cnt >= on_tgt || (!low_det && on_cnt >= CW'(BLANK)));
  wire flag_off = off && en && (on_cnt < on_tgt);
  wire start    = !g_q && ton && en && meas_vld && (inh_cnt == '0) && len_ok;

  assign gate = g_q & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0; hi_cnt <= '0; meas <= '0; meas_vld <= 1'b0;
      prev_on <= '0; on_cnt <= '0; on_tgt <= '0; inh_cnt <= '0; dw_cnt <= '0;
      g_q <= 1'b0; dt_sh <= 1'b0; rg_sh <= 1'b0; rg_arm <= 1'b0;
    end else begin
      low_cnt <= low_det  ? ((low_cnt == CMAX) ? low_cnt : low_cnt + CW'(1)) : '0;
      hi_cnt  <= !low_det ? ((hi_cnt  == CMAX) ? hi_cnt  : hi_cnt  + CW'(1)) : '0;

      if (fall && low_cnt >= CW'(ON_DLY)) begin
        meas     <= low_cnt;
        meas_vld <= 1'b1;
      end

      if (off) g_q <= 1'b0;
      else if (start) g_q <= 1'b1;

      if (start) begin
        on_cnt <= CW'(1);
        on_tgt <= CW'(lenv);
      end else if (g_q && !off) begin
        on_cnt <= on_cnt + CW'(1);
      end

      if (off) prev_on <= on_cnt;

      if (off) inh_cnt <= hf_sel ? CW'(INH_HF) : CW'(INH_LF);
      else if (inh_cnt != '0) inh_cnt <= inh_cnt - CW'(1);

      if (flag_off) dt_sh <= 1'b1;
      else if (dw_cnt != '0 && !low_det) dt_sh <= 1'b1;
      else if (ton) dt_sh <= 1'b0;

      if (off && !flag_off) dw_cnt <= CW'(DW_WIN);
      else if (dw_cnt != '0) dw_cnt <= low_det ? dw_cnt - CW'(1) : '0;

      if (ring_hit) rg_sh <= 1'b1;
      else if (ton) rg_sh <= 1'b0;

      if (fall && low_cnt < CW'(RNG_WIN)) rg_arm <= 1'b1;
      else if (low_det || ring_hit) rg_arm <= 1'b0;
    end
  end

  AST_EN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !g_q); // R12
  AST_MAX_ON: assert property (@(posedge clk) disable iff (!rst_n) g_q |-> on_cnt <= CW'(T_MAX)); // R7
  AST_INHIBIT_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(g_q) |-> $past(inh_cnt) == '0); // R9
  AST_NEEDS_MEAS: assert property (@(posedge clk) disable iff (!rst_n) !meas_vld |-> !g_q); // R3
  AST_GROWTH: assert property (@(posedge clk) disable iff (!rst_n) ($rose(g_q) && prev_on != '0) |-> SW'(on_tgt) * SW'(5) <= SW'(prev_on) * SW'(7)); // R10
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (g_q && en && on_cnt < CW'(BLANK) && on_cnt < on_tgt) |=> g_q); // R8
  AST_RISE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) $rose(g_q) |-> $past(low_cnt) == CW'(ON_DLY - 1)); // R1

endmodule

// File: tb/sr_gate_timer_tb.sv
module sr_gate_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, low_det = 1'b0, hf_sel = 1'b0, fb_shrink = 1'b0;
  logic [10:0] dead_cyc = 11'd30;
  logic gate;

  int errors = 0, checks = 0, cyc = 0;

  sr_gate_timer u_dut (.clk(clk), .rst_n(rst_n), .en(en), .low_det(low_det),
    .hf_sel(hf_sel), .fb_shrink(fb_shrink), .dead_cyc(dead_cyc), .gate(gate));

  always #5 clk = ~clk;

  // behavioural reference, in integers
  int m_lc, m_hc, m_meas, m_prev, m_oc, m_tgt, m_inh, m_dw;
  bit m_mv, m_g, m_dt, m_rg, m_arm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lc = 0; m_hc = 0; m_meas = 0; m_prev = 0; m_oc = 0; m_tgt = 0; m_inh = 0; m_dw = 0;
      m_mv = 0; m_g = 0; m_dt = 0; m_rg = 0; m_arm = 0;
    end else begin
      bit lo, fall, ton, off, foff, start, rhit;
      int raw, len;
      lo = low_det;
      fall = !lo && m_lc != 0;
      ton = lo && m_lc == 34;
      raw = m_meas - int'(dead_cyc) - 35 - (m_dt ? 125 : 0) - (m_rg ? 120 : 0) - (fb_shrink ? 140 : 0);
      len = raw;
      if (m_prev != 0 && len > (m_prev * 7) / 5) len = (m_prev * 7) / 5;
      if (len > 1050) len = 1050;
      off = m_g && (!en || m_oc >= m_tgt || (!lo && m_oc >= 30));
      foff = off && en && m_oc < m_tgt;
      start = !m_g && ton && en && m_mv && m_inh == 0 && raw > 0;
      rhit = m_arm && !lo && m_hc >= 15;
      if (off) m_prev = m_oc;
      if (off) m_inh = hf_sel ? 145 : 210; else if (m_inh > 0) m_inh--;
      if (foff || (m_dw > 0 && !lo)) m_dt = 1; else if (ton) m_dt = 0;
      if (off && !foff) m_dw = 13; else if (m_dw > 0) m_dw = lo ? m_dw - 1 : 0;
      if (rhit) m_rg = 1; else if (ton) m_rg = 0;
      if (fall && m_lc < 35) m_arm = 1; else if (lo || rhit) m_arm = 0;
      if (fall && m_lc >= 35) begin m_meas = m_lc; m_mv = 1; end
      if (start) begin m_oc = 1; m_tgt = len; end else if (m_g && !off) m_oc++;
      if (off) m_g = 0; else if (start) m_g = 1;
      m_lc = lo ? ((m_lc < 2047) ? m_lc + 1 : m_lc) : 0;
      m_hc = !lo ? ((m_hc < 2047) ? m_hc + 1 : m_hc) : 0;
    end
  end

  // monitor: per-clock compare plus pulse measurement
  int run = 0, last_len = 0, npulse = 0, lo_run = 0, rise_at = 0;
  bit g_prev = 0;
  always begin
    @(posedge clk); #1;
    cyc++;
    if (rst_n) begin
      checks++;
      if (gate !== (m_g & en)) begin
        errors++;
        $display("FAIL R2 model compare cyc=%0d actual=%0b expected=%0b", cyc, gate, m_g & en);
      end
    end
    lo_run = low_det ? lo_run + 1 : 0;
    if (gate && !g_prev) rise_at = lo_run;
    if (gate) run++;
    else if (run > 0) begin last_len = run; npulse++; run = 0; end
    g_prev = gate;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic period(input int lo, input int hi);
    low_det = 1'b1;
    repeat (lo) @(negedge clk);
    low_det = 1'b0;
    repeat (hi) @(negedge clk);
  endtask

  task automatic settle();
    for (int i = 0; i < 4; i++) period(300, 300);
  endtask

  initial begin
    int np;
    repeat (3) @(negedge clk);
    chk("R12 reset gate", gate, 0);
    rst_n = 1'b1;
    @(negedge clk);

    period(300, 300);
    chk("R3 no pulse before measurement", npulse, 0);
    period(300, 300);
    chk("R2 width 300-30-35", last_len, 235);
    chk("R1 rise on 35th sample", rise_at, 35);
    period(600, 300);
    chk("R2 uses previous measurement", last_len, 235);
    period(600, 300);
    chk("R10 growth cap 235*7/5", last_len, 329);
    period(600, 300);
    chk("R10 growth cap 329*7/5", last_len, 460);
    period(300, 300);
    chk("R8 flag ends pulse after blanking", last_len, 266);
    period(300, 300);
    chk("R4 dead-time shrink", last_len, 110);
    period(300, 300);
    chk("R4 shrink applies once, R10 cap", last_len, 154);
    settle();
    chk("R2 steady width", last_len, 235);

    period(20, 40);
    period(300, 300);
    chk("R5 ringing shrink", last_len, 115);
    settle();
    period(20, 10);
    period(300, 300);
    chk("R5 short gap is not ringing", last_len, 235);

    fb_shrink = 1'b1;
    period(300, 300);
    fb_shrink = 1'b0;
    chk("R6 feedback shrink", last_len, 95);
    settle();

    period(300, 100);
    np = npulse;
    period(300, 300);
    chk("R9 LF inhibit skips", npulse, np);
    hf_sel = 1'b1;
    settle();
    period(300, 100);
    np = npulse;
    period(300, 300);
    chk("R9 HF inhibit shorter", npulse, np + 1);
    chk("R9 HF pulse width", last_len, 235);
    hf_sel = 1'b0;
    settle();

    period(40, 300);
    chk("R8 blanking holds gate", last_len, 30);
    np = npulse;
    period(300, 300);
    chk("R11 non-positive width skipped", npulse, np);

    for (int i = 0; i < 12; i++) period(2000, 300);
    chk("R7 max on-time", last_len, 1050);

    settle();
    en = 1'b0;
    np = npulse;
    period(300, 300);
    chk("R12 disabled no pulse", npulse, np);
    chk("R12 gate low", gate, 0);
    en = 1'b1;
    settle();
    chk("R2 width after enable", last_len, 235);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule